// File: doc/BRIEF.md
# Register-Driven Serial Flash Command Engine

This block is a serial-flash master that runs one complete flash transaction each time software asks for one. Software programs a 32-bit command word that holds the opcode and a 24-bit address. It can also program a 32-bit data word for writes. It then writes the control register with a transmit byte count, a receive byte count, a clock select value and the start bit. The engine pulls chip select low and shifts the transmit bytes out MSB first in SPI mode 0. It then clocks in the requested response bytes and packs them into the data register. Chip select is then released.

A busy flag in the control register covers the whole transaction and a guard interval after chip select rises. Software polls this flag before it reads results or issues the next command. A page program of N bytes (N from 1 to 4) uses a transmit count of N+4. A status poll uses opcode 0x05 with one byte out and one byte in, and bit 0 of the returned byte is write-in-progress.

Top module: `spi_cmd_engine`

## Requirements
- R1: The register layout is: control at byte offset 0x0, command word at 0x4, data word at 0x8. Control fields are transmit count [3:0], receive count [7:4], start [8] (always reads 0), busy [16] (read-only) and clock select [25:24]. All other control bits read 0. A control write while idle without the start bit only updates the fields. The command and data words read back what was written.
- R2: After reset, csN is 1, sck and mosi are 0, and all three registers read 0.
- R3: A control write with start=1 while idle makes busy read 1 from the next cycle. Busy stays 1 until the guard interval after chip select release has passed.
- R4: Transmit byte k comes from the command word for k=0..3, in the order [7:0], [31:24], [23:16], [15:8]. For k=4..7 it comes from the data word, [7:0] first. Each byte is sent MSB first.
- R5: During receive bytes mosi is 0. Receive byte j is captured MSB first and lands in data bits [8j+7:8j]. When the receive count is nonzero, data bytes above the count read 0 after completion. When it is zero, the data word is left as written.
- R6: SPI mode 0: sck idles low, mosi changes only while sck is low, and miso is sampled on the rising sck edge.
- R7: With clock select value s, each sck high phase and each low phase lasts 2^s clock cycles.
- R8: csN falls exactly once per transaction and stays low across all transmit and receive bytes. After it rises it stays high for at least one sck period (2^(s+1) cycles) before another transaction can begin.
- R9: A transmit count above 8 is treated as 8. A receive count above 4 is treated as 4.
- R10: A start with both counts zero raises busy for the guard interval only. csN never falls.
- R11: A control write while busy is ignored entirely: it starts nothing and changes no field.
- R12: Writes to the command or data word while busy do not alter the bytes of the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for busAddr (combinational) |
| sckOut | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosiOut | output | 1 | Serial data to flash |
| misoIn | input | 1 | Serial data from flash |

## Verification
Busy is due half a clock after the write edge that carries the start bit. The bench reads it at the following falling clock edge. Serial bytes have no fixed cycle index, so a driver task queues the expected bytes and a monitor compares each one when its eighth rising sck edge arrives. Phase lengths and the chip select guard gap are counted in whole clock cycles at falling edges and compared against 2^s and 2^(s+1). The data register result is due in the cycle busy drops, so it is read only after a poll has seen busy at 0.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int REG_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int MAX_TX     = 8;
  localparam int MAX_RX     = 4;
  localparam int CMD_BYTES  = REG_W / BYTE_W;
  localparam int CNT_W      = 4;
  localparam int SEL_W      = 2;
  localparam int IDX_W      = $clog2(MAX_TX + MAX_RX + 1);
  localparam int BIT_IDX_W  = $clog2(BYTE_W);
  localparam int MAX_HALF   = 1 << ((1 << SEL_W) - 1);
  localparam int DIV_W      = $clog2(MAX_HALF) + 1;
  localparam int GAP_W      = DIV_W + 1;

  // control field positions (software-visible layout)
  localparam int TXF_LSB    = 0;
  localparam int RXF_LSB    = 4;
  localparam int START_POS  = 8;
  localparam int BUSY_POS   = 16;
  localparam int SEL_LSB    = 24;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_DATA = 4'h8;

  typedef struct packed {
    logic                 load;
    logic                 sample;
    logic                 byteDone;
    logic                 commit;
    logic                 active;
    logic                 busy;
    logic                 sckHigh;
    logic [IDX_W-1:0]     byteIdx;
    logic [BIT_IDX_W-1:0] bitIdx;
    logic [IDX_W-1:0]     txBytes;
    logic [IDX_W-1:0]     rxBytes;
  } ctrl2dp_t;

  function automatic logic [IDX_W-1:0] clampCnt(input logic [CNT_W-1:0] raw, input int lim);
    return (int'(raw) > lim) ? IDX_W'(lim) : IDX_W'(raw);
  endfunction
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [CNT_W-1:0] wrTx,
  input  logic [CNT_W-1:0] wrRx,
  input  logic             wrStart,
  input  logic [SEL_W-1:0] wrSel,
  output ctrl2dp_t         toDp,
  output logic [REG_W-1:0] ctrlView,
  output logic             sckOut,
  output logic             csN
);
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} state_t;

  state_t               state;
  logic [CNT_W-1:0]     txField;
  logic [CNT_W-1:0]     rxField;
  logic [SEL_W-1:0]     selField;
  logic [DIV_W-1:0]     divCnt;
  logic [GAP_W-1:0]     gapCnt;
  logic                 phaseHigh;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0]     byteIdx;

  logic [IDX_W-1:0]     txEff;
  logic [IDX_W-1:0]     rxEff;
  logic [IDX_W-1:0]     totalBytes;
  logic [IDX_W-1:0]     wrTotal;
  logic [DIV_W-1:0]     halfLast;
  logic [GAP_W-1:0]     gapLast;
  logic                 startOk;
  logic                 phaseEnd;

  assign txEff      = clampCnt(txField, MAX_TX);
  assign rxEff      = clampCnt(rxField, MAX_RX);
  assign totalBytes = txEff + rxEff;
  assign wrTotal    = clampCnt(wrTx, MAX_TX) + clampCnt(wrRx, MAX_RX);
  assign halfLast   = (DIV_W'(1) << selField) - DIV_W'(1);
  assign gapLast    = (GAP_W'(2) << selField) - GAP_W'(1);
  assign startOk    = ctrlWe && wrStart && (state == ST_IDLE);
  assign phaseEnd   = (state == ST_SHIFT) && (divCnt == halfLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      txField   <= '0;
      rxField   <= '0;
      selField  <= '0;
      divCnt    <= '0;
      gapCnt    <= '0;
      phaseHigh <= 1'b0;
      bitIdx    <= '0;
      byteIdx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ctrlWe) begin
            txField  <= wrTx;
            rxField  <= wrRx;
            selField <= wrSel;
            if (wrStart) begin
              divCnt    <= '0;
              gapCnt    <= '0;
              phaseHigh <= 1'b0;
              bitIdx    <= '0;
              byteIdx   <= '0;
              state     <= (wrTotal == '0) ? ST_GAP : ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (phaseEnd) begin
            divCnt <= '0;
            if (!phaseHigh) begin
              phaseHigh <= 1'b1;
            end else begin
              phaseHigh <= 1'b0;
              if (bitIdx == BIT_IDX_W'(BYTE_W - 1)) begin
                bitIdx <= '0;
                if (byteIdx == totalBytes - IDX_W'(1)) begin
                  state <= ST_GAP;
                end else begin
                  byteIdx <= byteIdx + IDX_W'(1);
                end
              end else begin
                bitIdx <= bitIdx + BIT_IDX_W'(1);
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (gapCnt == gapLast) begin
            gapCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sckOut = (state == ST_SHIFT) && phaseHigh;
  assign csN    = (state != ST_SHIFT);

  always_comb begin
    toDp          = '0;
    toDp.load     = startOk;
    toDp.sample   = phaseEnd && !phaseHigh;
    toDp.byteDone = phaseEnd && phaseHigh && (bitIdx == BIT_IDX_W'(BYTE_W - 1));
    toDp.commit   = (state == ST_GAP) && (gapCnt == gapLast);
    toDp.active   = (state == ST_SHIFT);
    toDp.busy     = (state != ST_IDLE);
    toDp.sckHigh  = sckOut;
    toDp.byteIdx  = byteIdx;
    toDp.bitIdx   = bitIdx;
    toDp.txBytes  = txEff;
    toDp.rxBytes  = rxEff;
  end

  always_comb begin
    ctrlView                          = '0;
    ctrlView[TXF_LSB +: CNT_W]        = txField;
    ctrlView[RXF_LSB +: CNT_W]        = rxField;
    ctrlView[BUSY_POS]                = (state != ST_IDLE);
    ctrlView[SEL_LSB +: SEL_W]        = selField;
  end

  // R11: fields frozen while a transaction or guard gap runs
  assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> ($stable(txField) && $stable(rxField) && $stable(selField)));

  // R9: byte pointer never runs past the clamped total
  assert_byte_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (byteIdx < totalBytes));

  // R6: bit pointer advances only as sck falls
  assert_bit_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SHIFT) && ($past(state) == ST_SHIFT) && (bitIdx != $past(bitIdx)))
      |-> ($past(phaseHigh) && !phaseHigh));
endmodule

// File: rtl/spi_eng_dpath.sv
module spi_eng_dpath
  import spi_eng_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  ctrl2dp_t          fromCtrl,
  input  logic [REG_W-1:0]  ctrlView,
  input  logic              misoIn,
  output logic              mosiOut
);
  logic [REG_W-1:0]                 cmdReg;
  logic [REG_W-1:0]                 dataReg;
  logic [MAX_TX-1:0][BYTE_W-1:0]    txArr;
  logic [BYTE_W-1:0]                inShift;
  logic [REG_W-1:0]                 rxWord;
  logic                             cmdWe;
  logic                             dataWe;
  logic [IDX_W-1:0]                 rxPos;

  assign cmdWe  = busWe && (busAddr == ADDR_W'(OFS_CMD));
  assign dataWe = busWe && (busAddr == ADDR_W'(OFS_DATA));
  assign rxPos  = fromCtrl.byteIdx - fromCtrl.txBytes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (cmdWe) begin
      cmdReg <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (fromCtrl.commit && (fromCtrl.rxBytes != '0)) begin
      dataReg <= rxWord;
    end else if (dataWe) begin
      dataReg <= busWdata;
    end
  end

  // snapshot of the outgoing stream, taken at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txArr <= '0;
    end else if (fromCtrl.load) begin
      for (int i = 0; i < MAX_TX; i++) begin
        if (i == 0) begin
          txArr[i] <= cmdReg[BYTE_W-1:0];
        end else if (i < CMD_BYTES) begin
          txArr[i] <= cmdReg[BYTE_W*(CMD_BYTES-i) +: BYTE_W];
        end else begin
          txArr[i] <= dataReg[BYTE_W*(i-CMD_BYTES) +: BYTE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift <= '0;
      rxWord  <= '0;
    end else begin
      if (fromCtrl.load) begin
        rxWord <= '0;
      end
      if (fromCtrl.sample) begin
        inShift <= {inShift[BYTE_W-2:0], misoIn};
      end
      if (fromCtrl.byteDone && (fromCtrl.byteIdx >= fromCtrl.txBytes)) begin
        for (int j = 0; j < MAX_RX; j++) begin
          if (rxPos == IDX_W'(j)) begin
            rxWord[BYTE_W*j +: BYTE_W] <= inShift;
          end
        end
      end
    end
  end

  always_comb begin
    mosiOut = 1'b0;
    for (int i = 0; i < MAX_TX; i++) begin
      if (fromCtrl.active && (fromCtrl.byteIdx == IDX_W'(i)) &&
          (fromCtrl.byteIdx < fromCtrl.txBytes)) begin
        mosiOut = txArr[i][BIT_IDX_W'(BYTE_W - 1) - fromCtrl.bitIdx];
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFS_CTRL): busRdata = ctrlView;
      ADDR_W'(OFS_CMD):  busRdata = cmdReg;
      ADDR_W'(OFS_DATA): busRdata = dataReg;
      default:           busRdata = '0;
    endcase
  end

  // R12: outgoing snapshot untouched for the life of a transaction
  assert_shadow_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    (fromCtrl.busy && $past(fromCtrl.busy)) |-> $stable(txArr));

  // R6: serial output held steady across each high phase
  assert_mosi_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fromCtrl.sckHigh && $past(fromCtrl.sckHigh)) |-> $stable(mosiOut));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sckOut,
  output logic              csN,
  output logic              mosiOut,
  input  logic              misoIn
);
  ctrl2dp_t         link;
  logic [REG_W-1:0] ctrlView;
  logic             ctrlWe;

  assign ctrlWe = busWe && (busAddr == ADDR_W'(OFS_CTRL));

  spi_eng_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .wrTx     (busWdata[TXF_LSB +: CNT_W]),
    .wrRx     (busWdata[RXF_LSB +: CNT_W]),
    .wrStart  (busWdata[START_POS]),
    .wrSel    (busWdata[SEL_LSB +: SEL_W]),
    .toDp     (link),
    .ctrlView (ctrlView),
    .sckOut   (sckOut),
    .csN      (csN)
  );

  spi_eng_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .fromCtrl (link),
    .ctrlView (ctrlView),
    .misoIn   (misoIn),
    .mosiOut  (mosiOut)
  );
endmodule

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busWe;
  logic [3:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        sck, csN, mosi;
  logic        miso = 1'b0;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  spi_cmd_engine i_spi_cmd_engine (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .sckOut(sck), .csN(csN), .mosiOut(mosi), .misoIn(miso)
  );

  logic [7:0] expQ[$];
  logic [7:0] respBytes[12];
  string      curReq = "R4";
  int         expHalf = 1;
  int         prevHalf = 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash responder and byte monitor
  int         rBit = 0;
  int         mBits = 0;
  int         csFalls = 0;
  logic [7:0] mByte = '0;
  logic [7:0] eByte;

  always @(negedge csN) begin
    csFalls++;
    rBit  = 0;
    mBits = 0;
    miso  = respBytes[0][7];
  end

  always @(negedge sck) begin
    if (csN === 1'b0) begin
      rBit++;
      if (rBit < 96) miso = respBytes[rBit/8][7 - (rBit%8)];
    end
  end

  always @(posedge sck) begin
    if (csN === 1'b0) begin
      mByte = {mByte[6:0], mosi};
      mBits++;
      if (mBits == 8) begin
        mBits = 0;
        if (expQ.size() == 0) begin
          check({curReq, " unexpected byte"}, {24'h0, mByte}, 32'hFFFF_FFFF);
        end else begin
          eByte = expQ.pop_front();
          check({curReq, " serial byte"}, {24'h0, mByte}, {24'h0, eByte});
        end
      end
    end
  end

  // phase and gap timing monitor
  int   hiCnt = 0, loCnt = 0, gapCnt = 0;
  bit   seenTxn = 0, mosiMoved = 0;
  logic prevSck = 1'b0, prevMosi = 1'b0, prevCs = 1'b1;

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (sck) begin
        hiCnt++;
        if (loCnt > 0) begin
          check("R7 low phase", loCnt, expHalf);
          loCnt = 0;
        end
        if (prevSck && (mosi !== prevMosi)) mosiMoved = 1;
      end else begin
        if (hiCnt > 0) begin
          check("R7 high phase", hiCnt, expHalf);
          check("R6 mosi held while sck high", 32'(mosiMoved), 0);
          hiCnt = 0;
          mosiMoved = 0;
        end
        if (!csN) loCnt++;
      end
      if (csN) begin
        if (!prevCs) prevHalf = expHalf;
        gapCnt++;
      end else begin
        if (prevCs && seenTxn) check("R8 guard gap", 32'(gapCnt >= 2*prevHalf), 1);
        seenTxn = 1;
        gapCnt  = 0;
      end
      prevSck  = sck;
      prevMosi = mosi;
      prevCs   = csN;
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  // driver: queue expected bytes, launch, wait, check results
  task automatic runTxn(input string req, input logic [31:0] cmd, input logic [31:0] data,
                        input int tx, input int rx, input int sel, input bit midMess);
    logic [7:0]  cb[4];
    logic [31:0] expRx, expData, rd, ctrlW;
    int tE, rE, falls0, n;
    tE = (tx > 8) ? 8 : tx;
    rE = (rx > 4) ? 4 : rx;
    curReq = req;
    cb[0] = cmd[7:0]; cb[1] = cmd[31:24]; cb[2] = cmd[23:16]; cb[3] = cmd[15:8];
    for (int i = 0; i < tE; i++) expQ.push_back((i < 4) ? cb[i] : data[8*(i-4) +: 8]);
    for (int j = 0; j < rE; j++) expQ.push_back(8'h00);
    expRx = '0;
    for (int j = 0; j < rE; j++) expRx[8*j +: 8] = respBytes[tE + j];
    expData = (rE > 0) ? expRx : data;
    expHalf = 1 << sel;
    busWrite(4'h4, cmd);
    busWrite(4'h8, data);
    falls0 = csFalls;
    ctrlW = (32'(sel) << 24) | 32'h100 | (32'(rx & 15) << 4) | 32'(tx & 15);
    busWrite(4'h0, ctrlW);
    busRead(4'h0, rd);
    check("R3 busy after start", {31'h0, rd[16]}, 1);
    if (midMess) begin
      busWrite(4'h0, 32'h0000_0111);
      busWrite(4'h4, ~cmd);
      busWrite(4'h8, ~data);
      if (rE == 0) expData = ~data;
    end
    n = 0;
    do begin
      busRead(4'h0, rd);
      n++;
    end while (rd[16] && n < 20000);
    check("R3 busy clears", {31'h0, rd[16]}, 0);
    check({req, " all bytes sent"}, expQ.size(), 0);
    expQ.delete();
    check("R11 control fields kept", rd & 32'h0300_00FF, ctrlW & 32'h0300_00FF);
    busRead(4'h8, rd);
    check("R5 data word result", rd, expData);
    if (midMess) begin
      busRead(4'h4, rd);
      check("R12 command write landed", rd, ~cmd);
    end
    if (tE + rE == 0) check("R10 no chip select", csFalls - falls0, 0);
    else              check("R8 one chip select", csFalls - falls0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL R3 watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 12; i++) respBytes[i] = 8'h40 + 8'(i);
    rstN = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R2
    check("R2 csN", {31'h0, csN}, 1);
    check("R2 sck", {31'h0, sck}, 0);
    check("R2 mosi", {31'h0, mosi}, 0);
    busRead(4'h0, rd); check("R2 control", rd, 0);
    busRead(4'h4, rd); check("R2 command", rd, 0);
    busRead(4'h8, rd); check("R2 data", rd, 0);
    // R1
    busWrite(4'h0, 32'h0200_0023);
    busRead(4'h0, rd); check("R1 control readback", rd, 32'h0200_0023);
    check("R1 no start csN", {31'h0, csN}, 1);
    busWrite(4'h4, 32'hDEAD_BEEF);
    busRead(4'h4, rd); check("R1 command readback", rd, 32'hDEAD_BEEF);
    // status poll: opcode 0x05, 1 out, 1 in
    respBytes[1] = 8'h03;
    runTxn("R4", 32'h0000_0005, 32'h0, 1, 1, 0, 0);
    // read 4 bytes
    respBytes[4] = 8'hA1; respBytes[5] = 8'hB2; respBytes[6] = 8'hC3; respBytes[7] = 8'hD4;
    runTxn("R4", 32'h1234_5603, 32'h0, 4, 4, 1, 0);
    // page program of 2 bytes
    runTxn("R4", 32'h0001_0002, 32'hAABB_CCDD, 6, 0, 3, 0);
    // full 8-byte transmit
    runTxn("R4", 32'h8877_6602, 32'h1122_3344, 8, 0, 0, 0);
    // clamping
    respBytes[8] = 8'h5A; respBytes[9] = 8'hA5; respBytes[10] = 8'h3C; respBytes[11] = 8'hC3;
    runTxn("R9", 32'hCAFE_F00D, 32'h7654_3210, 15, 15, 0, 0);
    // writes while busy
    respBytes[5] = 8'h9E; respBytes[6] = 8'h1F;
    runTxn("R12", 32'h0F0E_0D0B, 32'h0000_00E7, 5, 2, 2, 1);
    runTxn("R12", 32'h0403_0202, 32'h0000_6655, 6, 0, 1, 1);
    // zero counts
    runTxn("R10", 32'h0000_0006, 32'h1357_9BDF, 0, 0, 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule